// File: doc/BRIEF.md
# Shared-Counter Ramp Converter Back End

This block holds the digital half of a multi-channel ramp (Wilkinson) converter. One 12-bit Gray-code counter serves every channel. Each channel owns a 12-bit result register that stores the counter value on the cycle its comparator reports that the common ramp has crossed the channel's held voltage. A counter that changes one bit per step means a capture can never see a half-updated multi-bit value. The comparator pulses arrive already synchronised to the counting clock, which runs at 50 MHz in the target system. A full conversion of 4096 counts therefore takes about 82 µs.

A three-state sequencer controls each conversion. In `S_IDLE` it waits for `start`; that transition (*accept*) clears the counter and re-arms every channel. `S_RAMP` advances the counter once per clock. At the last code the *expire* transition leads to `S_DONE`, which lasts one cycle and raises `done`. The *retire* transition then returns to `S_IDLE`. Results keep their values until the next accepted start. Each result is also given in binary, decoded from its Gray value.

Top module: `wadc_backend`

## Requirements
- R1: After reset `busy`, `done`, every channel code (Gray and binary) and `count_gray` are all zero.
- R2: `start` clears the counter to Gray 0. The counter then advances once per clock through all 4096 codes, with `count_gray` equal to k XOR (k>>1) at count k. Adjacent values differ in exactly one bit.
- R3: `start` seen in idle at a clock edge raises `busy` after that edge. `busy` stays high for exactly 4096 cycles (counts 0 to 4095). Then `done` is high for exactly one cycle with `busy` low, and the block returns to idle.
- R4: A channel whose `cmp_fire` bit is high during the cycle where the count is k holds Gray(k) in its slice of `codes_gray` after the next edge. Channel i uses bits [12*i+11 : 12*i].
- R5: Only the first comparator pulse of a conversion is stored. Later pulses on the same channel leave its code unchanged.
- R6: A channel that never fires during a conversion reads full scale, Gray(4095) = 12'h800.
- R7: `start` asserted while a conversion is running is ignored. Counting and the end timing are unaffected.
- R8: Comparator pulses outside a conversion are ignored. Codes stay stable from `done` until the next accepted start.
- R9: Each slice of `codes_bin` equals the Gray-to-binary decode of the matching `codes_gray` slice.
- R10: Channels are independent. Every channel may fire at a different count, or all at the same count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a conversion (taken only when idle) |
| cmp_fire | input | NCH | Per-channel comparator pulse, synchronous to clk |
| busy | output | 1 | Conversion running |
| done | output | 1 | One-cycle end-of-conversion pulse |
| count_gray | output | 12 | Shared Gray counter value |
| codes_gray | output | 12*NCH | Per-channel Gray results |
| codes_bin | output | 12*NCH | Per-channel binary results |

## Verification
A counter that skipped or repeated a code shows up within one cycle on `count_gray`, either as a multi-bit step or as a value off the expected sequence. It also moves every later capture in the same conversion. A wrong sequencer state shows at the ports as a `busy` window that is not exactly 4096 cycles, a `done` pulse that is late or wider than one cycle, or a conversion restarted by a mid-ramp `start`. The bench detects each of these in the cycle it happens. A channel whose armed flag is lost or never cleared shows its error only at `done`. It then holds a later code than its first pulse, or a code other than full scale when it never fired.

// File: rtl/wadc_pkg.sv
package wadc_pkg;
    parameter int unsigned CNT_W = 12;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RAMP = 2'd1,
        S_DONE = 2'd2
    } wadc_state_e;

    function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/wadc_gray_ctr.sv
module wadc_gray_ctr
    import wadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] gray_o,
    output logic             at_max
);
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    always_comb begin
        bin_nxt = bin_q;
        if (clear) begin
            bin_nxt = '0;
        end else if (inc) begin
            bin_nxt = bin_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_o <= bin2gray(bin_nxt);
        end
    end

    assign at_max = (bin_q == {CNT_W{1'b1}});

    // R2: each advance flips exactly one output bit
    p_gray_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear) |=> ($countones(gray_o ^ $past(gray_o)) == 1));

    // R2: clear lands on Gray zero
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (gray_o == '0));
endmodule

// File: rtl/wadc_seq.sv
module wadc_seq
    import wadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic at_max,
    output logic clear,
    output logic inc,
    output logic busy_o,
    output logic done_o
);
    wadc_state_e state_q;
    wadc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start)  state_d = S_RAMP;   // accept
            S_RAMP:  if (at_max) state_d = S_DONE;   // expire
            S_DONE:              state_d = S_IDLE;   // retire
            default:             state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        clear  = 1'b0;
        inc    = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            S_IDLE:  clear = start;
            S_RAMP:  begin
                busy_o = 1'b1;
                inc    = !at_max;
            end
            S_DONE:  done_o = 1'b1;
            default: ;
        endcase
    end

    // R3: done lasts one cycle
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: an accepted start begins a conversion
    p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> busy_o);

    // R7: a running conversion continues until the last count, whatever start does
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !at_max) |=> (busy_o && !clear));
endmodule

// File: rtl/wadc_chan.sv
module wadc_chan
    import wadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             sample,
    input  logic             fire,
    input  logic [CNT_W-1:0] count_gray,
    output logic [CNT_W-1:0] code_o
);
    localparam logic [CNT_W-1:0] FULL_GRAY = bin2gray({CNT_W{1'b1}});

    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o  <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            code_o  <= FULL_GRAY;
            armed_q <= 1'b1;
        end else if (sample && fire && armed_q) begin
            code_o  <= count_gray;
            armed_q <= 1'b0;
        end
    end

    // R5: once captured, the code does not change until re-armed
    p_hold_after_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !load) |=> $stable(code_o));

    // R8: pulses outside a conversion do not change the code
    p_idle_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample && !load) |=> $stable(code_o));
endmodule

// File: rtl/wadc_backend.sv
module wadc_backend
    import wadc_pkg::*;
#(
    parameter int unsigned NCH = 36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NCH-1:0]       cmp_fire,
    output logic                 busy,
    output logic                 done,
    output logic [CNT_W-1:0]     count_gray,
    output logic [NCH*CNT_W-1:0] codes_gray,
    output logic [NCH*CNT_W-1:0] codes_bin
);
    localparam int unsigned BUS_W = NCH * CNT_W;

    logic clear;
    logic inc;
    logic at_max;

    wadc_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .at_max (at_max),
        .clear  (clear),
        .inc    (inc),
        .busy_o (busy),
        .done_o (done)
    );

    wadc_gray_ctr u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .inc    (inc),
        .gray_o (count_gray),
        .at_max (at_max)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        wadc_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (clear),
            .sample     (busy),
            .fire       (cmp_fire[c]),
            .count_gray (count_gray),
            .code_o     (codes_gray[c*CNT_W +: CNT_W])
        );
        assign codes_bin[c*CNT_W +: CNT_W] = gray2bin(codes_gray[c*CNT_W +: CNT_W]);
    end

    // R9: decoded output re-encodes to the stored Gray value
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            a_bin_roundtrip_r9: assert (bin2gray(codes_bin[c*CNT_W +: CNT_W]) == codes_gray[c*CNT_W +: CNT_W]);
        end
    end

    if (BUS_W == 0) begin : g_bad_width
        initial $display("wadc_backend: NCH must be nonzero");
    end
endmodule

// File: tb/wadc_backend_tb_top.sv
module wadc_backend_tb_top;
    localparam int NCH = 8;
    localparam int W = 12;
    localparam int LAST = 4095;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NCH-1:0] cmp_fire = '0;
    logic busy, done;
    logic [W-1:0] count_gray;
    logic [NCH*W-1:0] codes_gray, codes_bin;

    always #5 clk = ~clk;

    wadc_backend #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_fire(cmp_fire),
        .busy(busy), .done(done), .count_gray(count_gray),
        .codes_gray(codes_gray), .codes_bin(codes_bin)
    );

    typedef struct {
        int ch;
        logic [W-1:0] g;
        logic [W-1:0] b;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    int fire1 [NCH];
    int fire2 [NCH];

    function automatic logic [W-1:0] to_gray(input int k);
        logic [W-1:0] v;
        v = W'(k);
        return v ^ (v >> 1);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: at each done pulse, pop and compare all expected channel results
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                for (int c = 0; c < NCH; c++) begin
                    if (sb_q.size() == 0) begin
                        chk(0, "R4 scoreboard empty", 0, 1);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        chk(codes_gray[e.ch*W +: W] == e.g, e.req, codes_gray[e.ch*W +: W], e.g);
                        chk(codes_bin[e.ch*W +: W] == e.b, "R9 binary result", codes_bin[e.ch*W +: W], e.b);
                    end
                end
            end
        end
    end

    // driver: one full conversion with the fire schedule in fire1/fire2
    task automatic run_conv(input bit mid_start);
        int bad_seq = 0;
        int bad_busy = 0;
        int bad_step = 0;
        int at101 = -1;
        logic [W-1:0] prev;
        for (int c = 0; c < NCH; c++) begin
            exp_t e;
            int k;
            k = (fire1[c] >= 0) ? fire1[c] : LAST;
            e.ch = c;
            e.g = to_gray(k);
            e.b = W'(k);
            e.req = (fire1[c] < 0) ? "R6 unfired full scale" :
                    (fire2[c] >= 0) ? "R5 first pulse kept" : "R4 R10 captured count";
            sb_q.push_back(e);
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3 busy after accept", busy, 1);
        chk(count_gray == '0, "R2 counter cleared", count_gray, 0);
        prev = count_gray;
        for (int k = 0; k <= LAST; k++) begin
            if (count_gray != to_gray(k)) bad_seq++;
            if (k > 0 && $countones(count_gray ^ prev) != 1) bad_step++;
            if (!busy || done) bad_busy++;
            if (k == 101) at101 = int'(count_gray);
            prev = count_gray;
            for (int c = 0; c < NCH; c++) begin
                cmp_fire[c] = (fire1[c] == k) || (fire2[c] == k);
            end
            start = (mid_start && (k == 100 || k == 2000));
            @(negedge clk);
        end
        cmp_fire = '0;
        start = 1'b0;
        chk(bad_seq == 0, "R2 counter sequence", bad_seq, 0);
        chk(bad_step == 0, "R2 single-bit steps", bad_step, 0);
        chk(bad_busy == 0, "R3 busy for 4096 cycles", bad_busy, 0);
        if (mid_start) chk(at101 == int'(to_gray(101)), "R7 mid-ramp start ignored", at101, to_gray(101));
        chk(done == 1'b1 && busy == 1'b0, "R3 done after last count", {done, busy}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R3 done single cycle", {done, busy}, 2'b00);
    endtask

    task automatic idle_pulses();
        logic [NCH*W-1:0] snap;
        snap = codes_gray;
        cmp_fire = '1;
        repeat (6) @(negedge clk);
        cmp_fire = '0;
        @(negedge clk);
        chk(codes_gray == snap, "R8 idle pulses ignored", codes_gray[W-1:0], snap[W-1:0]);
        chk(busy == 1'b0 && done == 1'b0, "R8 still idle", {busy, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
        chk(codes_gray == '0 && codes_bin == '0, "R1 reset codes", codes_gray[W-1:0], 0);
        chk(count_gray == '0, "R1 reset counter", count_gray, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // conversion 1: spread counts, both ends, one channel silent
        fire1 = '{0, LAST, -1, 1, 2048, 1000, 3, LAST - 1};
        fire2 = '{-1, -1, -1, -1, -1, -1, -1, -1};
        run_conv(0);
        idle_pulses();

        // conversion 2: repeated pulses and mid-ramp start requests
        fire1 = '{500, 9, 0, -1, 4000, 1, 2, 3};
        fire2 = '{600, 4095, 1, -1, 4001, 3000, 3, 4};
        run_conv(1);
        idle_pulses();

        // conversion 3: all channels together
        fire1 = '{777, 777, 777, 777, 777, 777, 777, 777};
        fire2 = '{-1, -1, -1, -1, -1, -1, -1, -1};
        run_conv(0);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R4 all results compared", sb_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule